// File: doc/BRIEF.md
# Touchscreen ADC Command Responder

This block is the device side of a byte-level serial link to a touchscreen and analog-sensing converter. The host shifts bytes in. For every byte it takes, the block loads a response byte that the link shifts back out on the next exchange. A byte with its control flag set names one of eight analog lanes. On the exchange after that, the block takes a snapshot of the lane's 12-bit value and returns the upper seven bits. The exchange after that returns the lower five bits, left-justified. Every later exchange returns zeros until a new control byte arrives.

The analog front end is not modelled. A sample bus gives a 12-bit value for each lane. A parameter selects whether a real panel is fitted. When none is fitted, the X lane reads all zeros and the Y lane reads all ones. A deselect pulse ends a transaction unless the host has asked for chip-select hold. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `tsadc_responder`

## Requirements
- R1: After reset, and whenever no control byte is held, `xfer_miso` is 0x00 and every accepted byte returns 0x00.
- R2: A byte with bit 7 set is a control byte, and its bits [6:4] pick the lane. The first accepted byte after it snapshots that lane and returns {1'b0, value[11:5]}.
- R3: The second accepted byte after a control byte returns {value[4:0], 3'b000}. The value is the one taken by the snapshot in R2, even if the sample input has changed since.
- R4: Every accepted byte after the second returns 0x00 until the next control byte.
- R5: A control byte restarts the sequence at any step. Its own response is the one due at the step it arrived in.
- R6: Lane codes are 0 X position, 1 Y position, 2 pressure Z1, 3 pressure Z2, 4 battery, 5 temperature A, 6 microphone and 7 temperature B. Code k reads `samples[12k+11:12k]`. With `PANEL_PRESENT`=0, the X lane reads 0x000 and the Y lane reads 0xFFF, whatever the sample bus holds.
- R7: A `cs_release` pulse with `cs_hold` low drops the held control byte. Later bytes return 0x00 as in R1.
- R8: A `cs_release` pulse with `cs_hold` high leaves the sequence at the step it had reached.
- R9: A byte strobed in the same cycle as `cs_release` is ignored, and `xfer_miso` keeps its value.
- R10: `xfer_miso` changes only in the cycle after an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | One-cycle strobe: a received byte is on `xfer_mosi` |
| xfer_mosi | input | 8 | Byte received from the host |
| xfer_miso | output | 8 | Response byte for the next exchange |
| cs_release | input | 1 | One-cycle strobe: the host has deselected the device |
| cs_hold | input | 1 | Chip-select hold requested; qualifies `cs_release` |
| samples | input | 96 | Eight 12-bit lane values, lane k at bits [12k+11:12k] |

## Verification
The bench sends a control byte in the middle of a sequence. A design that drops the in-flight response, or that does not restart, returns the wrong half or stale zeros. It changes the sample after the upper half has gone out. A design that reads the lane live, instead of using the snapshot, corrupts the lower half. It sends deselect pulses with hold both on and off, and sends deselects in the same cycle as a byte. A wrong design then either loses a held transaction or accepts a byte the host abandoned. It also reads the placeholder X and Y lanes, which show whether the no-panel tie-off overrides the sample bus.

// File: rtl/tsadc_pkg.sv
package tsadc_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_ARMED = 2'd1,
    ST_HIGH  = 2'd2,
    ST_DONE  = 2'd3
  } tsadc_step_e;

  localparam int unsigned LANE_X = 0;
  localparam int unsigned LANE_Y = 1;
endpackage

// File: rtl/tsadc_rst_sync.sv
module tsadc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tsadc_chan_mux.sv
module tsadc_chan_mux #(
  parameter int unsigned NUM_CH        = 8,
  parameter int unsigned RES_W         = 12,
  parameter bit          PANEL_PRESENT = 1'b0,
  localparam int unsigned CH_W         = $clog2(NUM_CH)
) (
  input  logic [NUM_CH*RES_W-1:0] samples,
  input  logic [CH_W-1:0]         sel,
  output logic [RES_W-1:0]        value
);
  import tsadc_pkg::*;

  logic [RES_W-1:0] lane [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    if (!PANEL_PRESENT && g == LANE_X) begin : g_tie_x
      assign lane[g] = '0;
    end else if (!PANEL_PRESENT && g == LANE_Y) begin : g_tie_y
      assign lane[g] = '1;
    end else begin : g_live
      assign lane[g] = samples[g*RES_W +: RES_W];
    end
  end

  assign value = lane[sel];
endmodule

// File: rtl/tsadc_cmd_latch.sv
module tsadc_cmd_latch #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] byte_in,
  output logic              is_ctrl,
  output logic [CH_W-1:0]   chan
);
  logic [CH_W-1:0] chan_q, chan_d;
  logic            chan_en;

  assign is_ctrl = byte_in[DATA_W-1];
  assign chan_en = accept && is_ctrl;

  always_comb begin
    chan_d = chan_q;
    if (chan_en) chan_d = byte_in[DATA_W-2 -: CH_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chan_q <= '0;
    else if (chan_en) chan_q <= chan_d;
  end

  assign chan = chan_q;

  p_chan_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_ctrl) |=> (chan_q == $past(byte_in[DATA_W-2 -: CH_W])));
endmodule

// File: rtl/tsadc_seq.sv
module tsadc_seq #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RES_W  = 12,
  localparam int unsigned HI_W  = DATA_W - 1,
  localparam int unsigned LO_W  = RES_W - HI_W,
  localparam int unsigned PAD_W = DATA_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              is_ctrl,
  input  logic              drop,
  input  logic [RES_W-1:0]  lane_value,
  output logic [DATA_W-1:0] tx
);
  import tsadc_pkg::*;

  tsadc_step_e       step_q, step_d;
  logic [RES_W-1:0]  cap_q, cap_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              step_en, cap_en, tx_en;

  assign step_en = accept || drop;
  assign cap_en  = accept && (step_q == ST_ARMED);
  assign tx_en   = accept;

  always_comb begin
    step_d = step_q;
    cap_d  = cap_q;
    tx_d   = tx_q;
    if (drop) begin
      step_d = ST_EMPTY;
    end else if (accept) begin
      unique case (step_q)
        ST_ARMED: begin
          cap_d  = lane_value;
          tx_d   = {1'b0, lane_value[RES_W-1 -: HI_W]};
          step_d = ST_HIGH;
        end
        ST_HIGH: begin
          tx_d   = {cap_q[LO_W-1:0], {PAD_W{1'b0}}};
          step_d = ST_DONE;
        end
        default: begin
          tx_d   = '0;
        end
      endcase
      if (is_ctrl) step_d = ST_ARMED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= ST_EMPTY;
    else if (step_en) step_q <= step_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (tx_en) tx_q <= tx_d;
  end

  assign tx = tx_q;

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (step_q == ST_EMPTY)) |=> (tx_q == '0));
  p_done_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (step_q == ST_DONE)) |=> (tx_q == '0));
  p_high_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (step_q == ST_ARMED)) |=> (tx_q[DATA_W-1] == 1'b0));
  p_low_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (step_q == ST_HIGH)) |=> (tx_q[PAD_W-1:0] == '0));
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_ctrl && !drop) |=> (step_q == ST_ARMED));
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (step_q == ST_EMPTY));
endmodule

// File: rtl/tsadc_responder.sv
module tsadc_responder #(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned RES_W         = 12,
  parameter int unsigned NUM_CH        = 8,
  parameter bit          PANEL_PRESENT = 1'b0,
  localparam int unsigned CH_W         = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    xfer_valid,
  input  logic [DATA_W-1:0]       xfer_mosi,
  output logic [DATA_W-1:0]       xfer_miso,
  input  logic                    cs_release,
  input  logic                    cs_hold,
  input  logic [NUM_CH*RES_W-1:0] samples
);
  logic            rst_n_sync;
  logic            accept, drop, is_ctrl;
  logic [CH_W-1:0] chan;
  logic [RES_W-1:0] lane_value;

  assign accept = xfer_valid && !cs_release;
  assign drop   = cs_release && !cs_hold;

  tsadc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  tsadc_cmd_latch #(.DATA_W(DATA_W), .CH_W(CH_W)) u_cmd (
    .clk(clk), .rst_n(rst_n_sync), .accept(accept), .byte_in(xfer_mosi),
    .is_ctrl(is_ctrl), .chan(chan)
  );

  tsadc_chan_mux #(.NUM_CH(NUM_CH), .RES_W(RES_W), .PANEL_PRESENT(PANEL_PRESENT)) u_mux (
    .samples(samples), .sel(chan), .value(lane_value)
  );

  tsadc_seq #(.DATA_W(DATA_W), .RES_W(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_n_sync), .accept(accept), .is_ctrl(is_ctrl),
    .drop(drop), .lane_value(lane_value), .tx(xfer_miso)
  );

  p_miso_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !accept |=> $stable(xfer_miso));
  p_clash_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (xfer_valid && cs_release) |=> $stable(xfer_miso));
endmodule

// File: tb/tsadc_responder_bench.sv
module tsadc_responder_bench;
  logic        clk;
  logic        rst_n;
  logic        xfer_valid;
  logic [7:0]  xfer_mosi;
  logic [7:0]  xfer_miso;
  logic        cs_release;
  logic        cs_hold;
  logic [95:0] samples;
  logic [11:0] smp [8];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int          m_step;
  logic [2:0]  m_chan;
  logic [11:0] m_cap;
  logic [7:0]  m_tx;

  for (genvar i = 0; i < 8; i++) begin : g_pack
    assign samples[i*12 +: 12] = smp[i];
  end

  tsadc_responder u_tsadc_responder (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_mosi(xfer_mosi),
    .xfer_miso(xfer_miso), .cs_release(cs_release), .cs_hold(cs_hold),
    .samples(samples)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [11:0] lane_val(input logic [2:0] ch);
    if (ch == 3'd0) return 12'h000;
    if (ch == 3'd1) return 12'hFFF;
    return smp[ch];
  endfunction

  function automatic void model_byte(input logic [7:0] b);
    if (m_step == 1) begin
      m_cap  = lane_val(m_chan);
      m_tx   = {1'b0, m_cap[11:5]};
      m_step = 2;
    end else if (m_step == 2) begin
      m_tx   = {m_cap[4:0], 3'b000};
      m_step = 3;
    end else begin
      m_tx   = 8'h00;
    end
    if (b[7]) begin
      m_chan = b[6:4];
      m_step = 1;
    end
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (xfer_miso !== exp) begin
      errors++;
      $display("FAIL %s: miso=%02h expected %02h", req, xfer_miso, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input string req);
    @(negedge clk);
    xfer_valid = 1'b1;
    xfer_mosi  = b;
    @(negedge clk);
    xfer_valid = 1'b0;
    model_byte(b);
    check(req, m_tx);
  endtask

  task automatic release_cs(input logic hold, input logic with_byte, input string req);
    @(negedge clk);
    cs_release = 1'b1;
    cs_hold    = hold;
    xfer_valid = with_byte;
    xfer_mosi  = 8'hA5;
    @(negedge clk);
    cs_release = 1'b0;
    xfer_valid = 1'b0;
    if (!hold) m_step = 0;
    check(req, m_tx);
  endtask

  always @(posedge clk) begin
    if (!done && $time > 64'd1_200_000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    rst_n = 1'b0; xfer_valid = 1'b0; xfer_mosi = 8'h00;
    cs_release = 1'b0; cs_hold = 1'b0;
    for (int i = 0; i < 8; i++) smp[i] = 12'h100 * i[11:0] + 12'h035;
    m_step = 0; m_chan = 3'd0; m_cap = 12'h000; m_tx = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset", 8'h00);

    send(8'h12, "R1 idle byte");
    send(8'h7F, "R1 idle byte");

    // R2/R3/R4 on battery lane (code 4), value 0x435
    send(8'hC0, "R2 control byte response");
    send(8'h00, "R2 upper seven bits");
    send(8'h00, "R3 lower five bits");
    send(8'h00, "R4 trailing zero");
    send(8'h33, "R4 trailing zero");

    // R6 placeholder lanes
    smp[0] = 12'hABC; smp[1] = 12'h123;
    send(8'h80, "R6 ctrl X");
    send(8'h00, "R6 X upper");
    send(8'h00, "R6 X lower");
    send(8'h90, "R6 ctrl Y");
    send(8'h00, "R6 Y upper");
    send(8'h00, "R6 Y lower");

    // R3 snapshot: change sample between halves
    smp[2] = 12'hF0F;
    send(8'hA0, "R3 ctrl Z1");
    send(8'h00, "R3 upper of 0xF0F");
    smp[2] = 12'h000;
    send(8'h00, "R3 lower from snapshot");

    // R5 restart mid-sequence
    smp[7] = 12'h5A5; smp[6] = 12'h3C3;
    send(8'hF0, "R5 ctrl B");
    send(8'hE0, "R5 restart during upper");
    send(8'h00, "R5 upper after restart");
    send(8'hF0, "R5 restart during lower");
    send(8'h00, "R5 upper again");

    // R7 / R8
    release_cs(1'b1, 1'b0, "R8 held release");
    send(8'h00, "R8 lower survives hold");
    send(8'hD0, "R7 ctrl");
    release_cs(1'b0, 1'b0, "R7 release keeps miso");
    send(8'h00, "R7 zeros after drop");

    // R9 clash, R10 hold
    send(8'hB0, "R9 ctrl");
    release_cs(1'b1, 1'b1, "R9 clash byte ignored");
    send(8'h00, "R9 upper still next");
    repeat (5) @(negedge clk);
    check("R10 idle cycles stable", m_tx);

    for (int n = 0; n < 500; n++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r == 0) release_cs(1'($urandom_range(0, 1)), 1'b0, "R7/R8 random release");
      else if (r == 1) release_cs(1'($urandom_range(0, 1)), 1'b1, "R9 random clash");
      else if (r == 2) smp[$urandom_range(0, 7)] = 12'($urandom);
      else if (r < 7) send({1'b1, 7'($urandom)}, "R5 random control");
      else send({1'b0, 7'($urandom)}, "R2/R3/R4 random data");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule